// File: doc/BRIEF.md
# Operand Offset Generator

This block forms the 16-bit offset of a memory operand from an addressing mode, four 16-bit register values and a displacement. Two of the registers serve as bases (`base0`, `base1`) and two as indexes (`idx0`, `idx1`). Six modes are offered:

- displacement only;
- one register alone;
- a base plus a displacement;
- an index plus a displacement;
- a base plus an index;
- a base plus an index plus a displacement.

A short displacement has its sign extended before the addition. Carries past bit 15 are dropped, so results wrap around.

A request is a single-cycle `req_i` pulse with the mode, the register selects and the displacement. One clock later the block answers with a single-cycle `done_o` pulse. At the same time it presents:

- the registered offset;
- a flag that marks an illegal mode or register combination;
- a flag that is high when `base1` fed the sum, so that a later stage can choose the stack segment.

The outputs then hold until the next request.

Top module: `opnd_ofs_gen`

## Requirements
- R1: Every clock edge with `req_i` high produces `done_o` high during the following cycle only. Back-to-back requests give back-to-back `done_o` pulses.
- R2: While `req_i` is low, `offset_o`, `illegal_o` and `stack_o` keep their last values, whatever the other inputs do.
- R3: Mode 0 (direct) returns the extended displacement as the offset.
- R4: With `disp_wide_i`=1 the displacement is `disp_i[15:0]`. With `disp_wide_i`=0 it is `disp_i[7:0]` sign-extended to 16 bits, and `disp_i[15:8]` is ignored.
- R5: Mode 1 (register only) returns the register named by `reg_sel_i`: 0=`base0`, 1=`base1`, 2=`idx0`, 3=`idx1`.
- R6: Mode 2 (based) returns the base named by `reg_sel_i` (0 or 1) plus the displacement.
- R7: Mode 3 (indexed) returns the index named by `reg_sel_i` (2 or 3) plus the displacement.
- R8: Mode 4 (based indexed) returns the base named by `reg_sel_i` (0 or 1) plus the index named by `idx_sel_i` (0=`idx0`, 1=`idx1`). The displacement is ignored.
- R9: Mode 5 returns the mode 4 sum plus the displacement.
- R10: All sums are taken modulo 65536.
- R11: `illegal_o` is 1, and `offset_o` and `stack_o` are 0, in any of these cases:
  - mode 6 or 7;
  - mode 2, 4 or 5 with `reg_sel_i` of 2 or 3;
  - mode 3 with `reg_sel_i` of 0 or 1.
- R12: For a legal request, `stack_o` is 1 exactly when `base1` contributes to the sum (mode 1, 2, 4 or 5 with `reg_sel_i`=1).
- R13: After reset, `done_o`, `offset_o`, `illegal_o` and `stack_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_i | input | 1 | Request strobe, one cycle per request |
| mode_i | input | 3 | Addressing mode code 0..5; 6 and 7 are illegal |
| reg_sel_i | input | 2 | Register select: 0 base0, 1 base1, 2 idx0, 3 idx1 |
| idx_sel_i | input | 1 | Index select for modes 4 and 5 |
| disp_i | input | 16 | Displacement |
| disp_wide_i | input | 1 | 1: full 16-bit displacement; 0: low byte, sign-extended |
| base0_i | input | 16 | First base register value |
| base1_i | input | 16 | Second base register value (stack base) |
| idx0_i | input | 16 | First index register value |
| idx1_i | input | 16 | Second index register value |
| done_o | output | 1 | Result valid pulse, one cycle after the request |
| offset_o | output | 16 | Registered operand offset |
| illegal_o | output | 1 | Illegal mode or register combination |
| stack_o | output | 1 | base1 contributed to the offset |

## Verification
The assertions assume that every input is a known value at each clock edge while reset is released. They also assume that `req_i` is sampled only at clock edges, so a request lasts exactly the cycles in which it is high.

The stimulus changes every input only on the falling clock edge, and it raises `req_i` for whole cycles. Between requests it deliberately disturbs the mode, selects, displacement and register values. This shows that the held result does not follow them, while it still keeps every input defined.

// File: rtl/opnd_ofs_pkg.sv
package opnd_ofs_pkg;

  typedef enum logic [2:0] {
    AM_DISP       = 3'd0,
    AM_REG        = 3'd1,
    AM_BASE_DISP  = 3'd2,
    AM_IDX_DISP   = 3'd3,
    AM_BASE_IDX   = 3'd4,
    AM_BASE_IDX_D = 3'd5
  } addr_mode_e;

  localparam logic [1:0] RS_BASE0 = 2'd0;
  localparam logic [1:0] RS_BASE1 = 2'd1;
  localparam logic [1:0] RS_IDX0  = 2'd2;
  localparam logic [1:0] RS_IDX1  = 2'd3;

  // Routing of one request through the adder.
  typedef struct packed {
    logic       use_a;     // first operand taken from reg_sel
    logic [1:0] a_code;    // register code of the first operand
    logic       use_b;     // second operand taken from an index register
    logic       b_code;    // 0 idx0, 1 idx1
    logic       use_disp;  // displacement enters the sum
    logic       illegal;   // combination rejected
    logic       stack;     // base1 feeds the sum
  } route_t;

endpackage

// File: rtl/opnd_ofs_disp_ext.sv
module opnd_ofs_disp_ext #(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic [OFS_W-1:0] disp_i,
  input  logic             wide_i,
  output logic [OFS_W-1:0] disp_o
);

  localparam int unsigned PAD_W = (OFS_W > SHORT_W) ? OFS_W - SHORT_W : 1;

  logic [OFS_W-1:0] short_ext;

  generate
    if (OFS_W > SHORT_W) begin : g_ext
      assign short_ext = {{PAD_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
    end else begin : g_pass
      assign short_ext = disp_i;
    end
  endgenerate

  always_comb begin
    if (wide_i) disp_o = disp_i;
    else        disp_o = short_ext;
  end

endmodule

// File: rtl/opnd_ofs_route.sv
module opnd_ofs_route
  import opnd_ofs_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] reg_sel_i,
  input  logic       idx_sel_i,
  output route_t     route_o
);

  logic sel_is_base;

  assign sel_is_base = ~reg_sel_i[1];

  always_comb begin
    route_o          = '0;
    route_o.a_code   = reg_sel_i;
    route_o.b_code   = idx_sel_i;
    case (mode_i)
      AM_DISP: begin
        route_o.use_disp = 1'b1;
      end
      AM_REG: begin
        route_o.use_a = 1'b1;
        route_o.stack = (reg_sel_i == RS_BASE1);
      end
      AM_BASE_DISP: begin
        route_o.use_a    = 1'b1;
        route_o.use_disp = 1'b1;
        route_o.illegal  = ~sel_is_base;
        route_o.stack    = (reg_sel_i == RS_BASE1);
      end
      AM_IDX_DISP: begin
        route_o.use_a    = 1'b1;
        route_o.use_disp = 1'b1;
        route_o.illegal  = sel_is_base;
      end
      AM_BASE_IDX: begin
        route_o.use_a   = 1'b1;
        route_o.use_b   = 1'b1;
        route_o.illegal = ~sel_is_base;
        route_o.stack   = (reg_sel_i == RS_BASE1);
      end
      AM_BASE_IDX_D: begin
        route_o.use_a    = 1'b1;
        route_o.use_b    = 1'b1;
        route_o.use_disp = 1'b1;
        route_o.illegal  = ~sel_is_base;
        route_o.stack    = (reg_sel_i == RS_BASE1);
      end
      default: begin
        route_o.illegal = 1'b1;
      end
    endcase
    if (route_o.illegal) begin
      route_o.use_a    = 1'b0;
      route_o.use_b    = 1'b0;
      route_o.use_disp = 1'b0;
      route_o.stack    = 1'b0;
    end
  end

endmodule

// File: rtl/opnd_ofs_sum.sv
module opnd_ofs_sum
  import opnd_ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  route_t           route_i,
  input  logic [OFS_W-1:0] base0_i,
  input  logic [OFS_W-1:0] base1_i,
  input  logic [OFS_W-1:0] idx0_i,
  input  logic [OFS_W-1:0] idx1_i,
  input  logic [OFS_W-1:0] disp_i,
  output logic [OFS_W-1:0] sum_o
);

  localparam int unsigned NREG = 4;

  logic [OFS_W-1:0] regs [NREG];
  logic [OFS_W-1:0] op_a, op_b, op_d;

  assign regs[0] = base0_i;
  assign regs[1] = base1_i;
  assign regs[2] = idx0_i;
  assign regs[3] = idx1_i;

  always_comb begin
    op_a = route_i.use_a ? regs[route_i.a_code] : '0;
    op_b = '0;
    if (route_i.use_b) op_b = route_i.b_code ? idx1_i : idx0_i;
    op_d = route_i.use_disp ? disp_i : '0;
    // Carry beyond the top bit is dropped by the result width.
    sum_o = op_a + op_b + op_d;
  end

endmodule

// File: rtl/opnd_ofs_gen.sv
module opnd_ofs_gen
  import opnd_ofs_pkg::*;
#(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             idx_sel_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic             disp_wide_i,
  input  logic [OFS_W-1:0] base0_i,
  input  logic [OFS_W-1:0] base1_i,
  input  logic [OFS_W-1:0] idx0_i,
  input  logic [OFS_W-1:0] idx1_i,
  output logic             done_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             illegal_o,
  output logic             stack_o
);

  route_t           route;
  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] sum;

  logic             done_q,  done_d;
  logic [OFS_W-1:0] ofs_q,   ofs_d;
  logic             ill_q,   ill_d;
  logic             stk_q,   stk_d;
  logic             res_en;

  opnd_ofs_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ext (
    .disp_i (disp_i),
    .wide_i (disp_wide_i),
    .disp_o (disp_ext)
  );

  opnd_ofs_route u_route (
    .mode_i    (mode_i),
    .reg_sel_i (reg_sel_i),
    .idx_sel_i (idx_sel_i),
    .route_o   (route)
  );

  opnd_ofs_sum #(.OFS_W(OFS_W)) u_sum (
    .route_i (route),
    .base0_i (base0_i),
    .base1_i (base1_i),
    .idx0_i  (idx0_i),
    .idx1_i  (idx1_i),
    .disp_i  (disp_ext),
    .sum_o   (sum)
  );

  // Next-state logic.
  always_comb begin
    res_en = req_i;
    done_d = req_i;
    ofs_d  = route.illegal ? '0 : sum;
    ill_d  = route.illegal;
    stk_d  = route.stack;
  end

  // Registers. rst_n is expected to be deasserted synchronously upstream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ofs_q  <= '0;
      ill_q  <= 1'b0;
      stk_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (res_en) begin
        ofs_q <= ofs_d;
        ill_q <= ill_d;
        stk_q <= stk_d;
      end
    end
  end

  assign done_o    = done_q;
  assign offset_o  = ofs_q;
  assign illegal_o = ill_q;
  assign stack_o   = stk_q;

  // Assertions guarding the result registers.
  assert_done_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);

  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !done_o);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(offset_o) && $stable(illegal_o) && $stable(stack_o)));

  assert_direct_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd0 && disp_wide_i) |=> (offset_o == $past(disp_i)));

  assert_illegal_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i[2] && mode_i[1]) |=> illegal_o);

  assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (offset_o == '0 && !stack_o));

  assert_stack_based_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd2 && reg_sel_i == 2'd1) |=> stack_o);

  assert_no_stack_index_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd3) |=> !stack_o);

endmodule

// File: tb/opnd_ofs_gen_tb_top.sv
module opnd_ofs_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  mode_i;
  logic [1:0]  reg_sel_i;
  logic        idx_sel_i;
  logic [15:0] disp_i;
  logic        disp_wide_i;
  logic [15:0] base0_i, base1_i, idx0_i, idx1_i;
  logic        done_o;
  logic [15:0] offset_o;
  logic        illegal_o;
  logic        stack_o;

  int checks;
  int errors;
  bit finished;

  logic [17:0] exp_q[$];   // {illegal, stack, offset}
  string       tag_q[$];
  logic [17:0] last_exp;
  bit          have_last;

  opnd_ofs_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .reg_sel_i(reg_sel_i), .idx_sel_i(idx_sel_i), .disp_i(disp_i),
    .disp_wide_i(disp_wide_i), .base0_i(base0_i), .base1_i(base1_i),
    .idx0_i(idx0_i), .idx1_i(idx1_i), .done_o(done_o),
    .offset_o(offset_o), .illegal_o(illegal_o), .stack_o(stack_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model taken from the requirements.
  function automatic logic [17:0] model(input logic [2:0] m, input logic [1:0] s,
                                        input logic x, input logic [15:0] d,
                                        input logic w);
    logic [15:0] dv, rv, iv, sum;
    logic        bad, stk;
    dv  = w ? d : {{8{d[7]}}, d[7:0]};                  // R4
    rv  = (s == 2'd0) ? base0_i : (s == 2'd1) ? base1_i :
          (s == 2'd2) ? idx0_i : idx1_i;
    iv  = x ? idx1_i : idx0_i;
    bad = 1'b0;
    stk = 1'b0;
    sum = 16'h0;
    case (m)
      3'd0: sum = dv;                                    // R3
      3'd1: begin sum = rv; stk = (s == 2'd1); end       // R5
      3'd2: begin bad = s[1];  sum = rv + dv; stk = (s == 2'd1); end // R6
      3'd3: begin bad = !s[1]; sum = rv + dv; end        // R7
      3'd4: begin bad = s[1];  sum = rv + iv; stk = (s == 2'd1); end // R8
      3'd5: begin bad = s[1];  sum = rv + iv + dv; stk = (s == 2'd1); end // R9
      default: bad = 1'b1;                               // R11
    endcase
    if (bad) begin sum = 16'h0; stk = 1'b0; end
    return {bad, stk, sum};
  endfunction

  task automatic do_req(input logic [2:0] m, input logic [1:0] s, input logic x,
                        input logic [15:0] d, input logic w, input string tag);
    mode_i = m; reg_sel_i = s; idx_sel_i = x; disp_i = d; disp_wide_i = w;
    req_i = 1'b1;
    exp_q.push_back(model(m, s, x, d, w));
    tag_q.push_back(tag);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      mode_i    = mode_i + 3'd3;
      reg_sel_i = reg_sel_i + 2'd1;
      idx_sel_i = ~idx_sel_i;
      disp_i    = disp_i ^ 16'h5A3C;
      base0_i   = base0_i + 16'h0101;
      @(negedge clk);
    end
  endtask

  task automatic set_regs();
    base0_i = 16'h1234; base1_i = 16'hFFF0; idx0_i = 16'h0010; idx1_i = 16'h8001;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 done without request: actual done=1 expected done=0");
        end else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({illegal_o, stack_o, offset_o} !== e) begin
            errors++;
            $display("FAIL %s: actual ill=%0b stk=%0b ofs=%h expected ill=%0b stk=%0b ofs=%h",
                     t, illegal_o, stack_o, offset_o, e[17], e[16], e[15:0]);
          end
          last_exp  = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        checks++;
        if ({illegal_o, stack_o, offset_o} !== last_exp) begin
          errors++;
          $display("FAIL R2 hold: actual ill=%0b stk=%0b ofs=%h expected ill=%0b stk=%0b ofs=%h",
                   illegal_o, stack_o, offset_o, last_exp[17], last_exp[16], last_exp[15:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0; have_last = 1'b0; last_exp = '0;
    rst_n = 1'b0; req_i = 1'b0; mode_i = 3'd0; reg_sel_i = 2'd0; idx_sel_i = 1'b0;
    disp_i = 16'h0; disp_wide_i = 1'b0;
    set_regs();
    repeat (3) @(negedge clk);
    // R13 reset state
    checks++;
    if ({done_o, illegal_o, stack_o, offset_o} !== 19'h0) begin
      errors++;
      $display("FAIL R13 reset: actual done=%0b ill=%0b stk=%0b ofs=%h expected all 0",
               done_o, illegal_o, stack_o, offset_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    do_req(3'd0, 2'd0, 1'b0, 16'hBEEF, 1'b1, "R3 direct wide");
    do_req(3'd0, 2'd0, 1'b0, 16'h1280, 1'b0, "R4 short negative");
    do_req(3'd0, 2'd0, 1'b0, 16'hAB7F, 1'b0, "R4 short positive");
    idle(3);
    set_regs();
    do_req(3'd1, 2'd0, 1'b0, 16'h0000, 1'b1, "R5 reg base0");
    do_req(3'd1, 2'd1, 1'b0, 16'h0000, 1'b1, "R5 R12 reg base1");
    do_req(3'd1, 2'd2, 1'b0, 16'h0000, 1'b1, "R5 reg idx0");
    do_req(3'd1, 2'd3, 1'b0, 16'h0000, 1'b1, "R5 reg idx1");
    do_req(3'd2, 2'd0, 1'b0, 16'h0005, 1'b0, "R6 based base0");
    do_req(3'd2, 2'd1, 1'b0, 16'h33FE, 1'b0, "R6 R12 based base1 neg");
    idle(2);
    set_regs();
    do_req(3'd3, 2'd3, 1'b0, 16'h1000, 1'b1, "R7 indexed idx1");
    do_req(3'd3, 2'd2, 1'b1, 16'h0080, 1'b0, "R7 indexed idx0 short");
    do_req(3'd4, 2'd0, 1'b0, 16'hAAAA, 1'b1, "R8 base0 idx0");
    do_req(3'd4, 2'd1, 1'b1, 16'h5555, 1'b0, "R8 R12 base1 idx1");
    do_req(3'd5, 2'd1, 1'b1, 16'h0020, 1'b1, "R9 R10 three-way wrap");
    do_req(3'd5, 2'd0, 1'b0, 16'h00F0, 1'b0, "R9 short neg");
    do_req(3'd2, 2'd1, 1'b0, 16'h0020, 1'b1, "R10 based wrap");
    idle(4);
    set_regs();
    do_req(3'd6, 2'd1, 1'b0, 16'h1111, 1'b1, "R11 mode 6");
    do_req(3'd7, 2'd0, 1'b0, 16'h1111, 1'b1, "R11 mode 7");
    do_req(3'd1, 2'd1, 1'b0, 16'h0000, 1'b1, "R12 legal between");
    do_req(3'd2, 2'd2, 1'b0, 16'h0004, 1'b1, "R11 based with index");
    do_req(3'd3, 2'd1, 1'b0, 16'h0004, 1'b1, "R11 indexed with base");
    do_req(3'd5, 2'd3, 1'b1, 16'h0004, 1'b1, "R11 base-index with index");
    idle(3);
    set_regs();
    do_req(3'd4, 2'd1, 1'b0, 16'h0000, 1'b1, "R1 R12 final");
    idle(3);

    // R1: every request answered exactly once
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 unanswered: actual pending=%0d expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule